// File: doc/BRIEF.md
# Row-Time Column Block Load Sequencer

This block controls a column demultiplexer that shares 256 analog driver outputs across 1280 column lines by loading them in five consecutive blocks during one row time. When a row begins, it opens the gate window of the target row and enables block 0. Each load strobe from the data source marks the current block as loaded and moves the enable on to the next block, so the columns fill in raster order. The `col_base` output gives the first column of the active block.

The gate window stays high while all five blocks are loaded. Each column line keeps its value on its own capacitance until the last block is done. After the fifth strobe the window closes. That falling edge stores the row, and a one-cycle `row_done` pulse follows. If a new row start arrives before the fifth block completes, the block flags `row_abort` and restarts the load sequence at block 0.

Top module: `dline_demux_seq`

## Requirements
- R1: While reset is asserted and after it is released, with no row start yet, `gate_win`, `row_done` and `row_abort` are 0, `blk_en` is all zeros, and `blk_idx` and `col_base` are 0.
- R2: A `row_start` in a cycle where `gate_win` is 0 raises `gate_win` on the next clock edge, with `blk_idx` = 0 and `blk_en` = 5'b00001.
- R3: While `gate_win` is 1, exactly one bit of `blk_en` is 1, and it is bit number `blk_idx`. While `gate_win` is 0, `blk_en` is all zeros.
- R4: While `gate_win` is 1, each `load_stb` sampled without `row_start` moves `blk_idx` from n to n+1, for n below 4. Without a strobe, `blk_idx` holds its value.
- R5: `col_base` equals 256 × `blk_idx`, so block n covers columns 256·n to 256·n+255.
- R6: `gate_win` stays 1 until a `load_stb` is sampled with `blk_idx` = 4, and falls on the next edge. It never falls for any other reason.
- R7: `row_done` is 1 for exactly one cycle: the first cycle in which `gate_win` is 0 after a completed fifth load.
- R8: A `row_start` sampled while `gate_win` is 1 has the following effects on the next edge: `row_abort` pulses for one cycle, `gate_win` stays 1 and `blk_idx` returns to 0. It wins over a `load_stb` in the same cycle, including a fifth one, so no `row_done` follows.
- R9: A `load_stb` sampled while `gate_win` is 0 and `row_start` is 0 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| row_start | input | 1 | Begin loading a new row |
| load_stb | input | 1 | Current block has been loaded by the data source |
| blk_en | output | 5 | One-hot block enables, bit n drives block n |
| blk_idx | output | 3 | Index of the active block |
| col_base | output | 11 | First column of the active block |
| gate_win | output | 1 | Gate window of the target row |
| row_done | output | 1 | One-cycle pulse after the row has been stored |
| row_abort | output | 1 | One-cycle pulse when a row start cuts a load short |

## Verification
The key collision is the fifth load strobe arriving in the same cycle as a new row start. In that case completion and restart compete for the gate window and the block index. The bench drives this case directly and also produces it at random by raising `row_start` rarely against dense strobes. It then checks that `row_abort` fires, that the gate stays open at block 0 and that no `row_done` appears. A second collision is a row start in the cycle where `row_done` is high. The bench checks that this is accepted as a plain start with no abort.

// File: rtl/dls_pkg.sv
package dls_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_LOAD = 1'b1
  } dls_phase_e;

  function automatic int unsigned idx_width(input int unsigned blocks);
    return (blocks > 1) ? $clog2(blocks) : 1;
  endfunction
endpackage

// File: rtl/dls_block_ctr.sv
module dls_block_ctr #(
  parameter int unsigned NUM_BLOCKS = 5,
  localparam int unsigned IDX_W = dls_pkg::idx_width(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BLOCKS - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;

  assign last = (idx_q == LAST_IDX);

  always_comb begin
    idx_en = clr | adv;
    idx_d  = idx_q;
    if (clr)       idx_d = '0;
    else if (adv)  idx_d = last ? '0 : IDX_W'(idx_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign idx = idx_q;
endmodule

// File: rtl/dls_gate_ctl.sv
module dls_gate_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic row_start,
  input  logic load_stb,
  input  logic last,
  output logic gate_win,
  output logic adv,
  output logic row_done,
  output logic row_abort
);
  import dls_pkg::*;

  dls_phase_e phase_q, phase_d;
  logic       done_q, done_d;
  logic       abort_q, abort_d;
  logic       finish;

  assign gate_win = (phase_q == PH_LOAD);
  assign adv      = gate_win & load_stb;
  assign finish   = adv & last & ~row_start;

  always_comb begin
    phase_d = phase_q;
    if (row_start)   phase_d = PH_LOAD;
    else if (finish) phase_d = PH_IDLE;
    done_d  = finish;
    abort_d = row_start & gate_win;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
      abort_q <= abort_d;
    end
  end

  assign row_done  = done_q;
  assign row_abort = abort_q;
endmodule

// File: rtl/dls_onehot_dec.sv
module dls_onehot_dec #(
  parameter int unsigned NUM_BLOCKS      = 5,
  parameter int unsigned LINES_PER_BLOCK = 256,
  localparam int unsigned IDX_W = dls_pkg::idx_width(NUM_BLOCKS),
  localparam int unsigned COL_W = $clog2(NUM_BLOCKS * LINES_PER_BLOCK)
) (
  input  logic                  gate_win,
  input  logic [IDX_W-1:0]      idx,
  output logic [NUM_BLOCKS-1:0] blk_en,
  output logic [COL_W-1:0]      col_base
);
  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_en
    assign blk_en[g] = gate_win & (idx == IDX_W'(g));
  end

  assign col_base = COL_W'(idx) * COL_W'(LINES_PER_BLOCK);
endmodule

// File: rtl/dline_demux_seq.sv
module dline_demux_seq #(
  parameter int unsigned NUM_BLOCKS      = 5,
  parameter int unsigned LINES_PER_BLOCK = 256,
  localparam int unsigned IDX_W = dls_pkg::idx_width(NUM_BLOCKS),
  localparam int unsigned COL_W = $clog2(NUM_BLOCKS * LINES_PER_BLOCK)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  row_start,
  input  logic                  load_stb,
  output logic [NUM_BLOCKS-1:0] blk_en,
  output logic [IDX_W-1:0]      blk_idx,
  output logic [COL_W-1:0]      col_base,
  output logic                  gate_win,
  output logic                  row_done,
  output logic                  row_abort
);
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  logic       adv;
  logic       last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  dls_gate_ctl u_gate (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .row_start (row_start),
    .load_stb  (load_stb),
    .last      (last),
    .gate_win  (gate_win),
    .adv       (adv),
    .row_done  (row_done),
    .row_abort (row_abort)
  );

  dls_block_ctr #(.NUM_BLOCKS(NUM_BLOCKS)) u_ctr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (row_start),
    .adv   (adv),
    .idx   (blk_idx),
    .last  (last)
  );

  dls_onehot_dec #(
    .NUM_BLOCKS      (NUM_BLOCKS),
    .LINES_PER_BLOCK (LINES_PER_BLOCK)
  ) u_dec (
    .gate_win (gate_win),
    .idx      (blk_idx),
    .blk_en   (blk_en),
    .col_base (col_base)
  );
endmodule

// File: rtl/dls_checker.sv
module dls_checker #(
  parameter int unsigned NUM_BLOCKS = 5,
  localparam int unsigned IDX_W = dls_pkg::idx_width(NUM_BLOCKS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  row_start,
  input logic                  load_stb,
  input logic [NUM_BLOCKS-1:0] blk_en,
  input logic [IDX_W-1:0]      blk_idx,
  input logic                  gate_win,
  input logic                  row_done,
  input logic                  row_abort
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BLOCKS - 1);

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (row_start && !gate_win) |=> (gate_win && blk_idx == '0));

  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gate_win |-> ($countones(blk_en) == 1 && blk_en[blk_idx]));

  p_idle_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_win |-> (blk_en == '0));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_win && load_stb && !row_start && blk_idx != LAST_IDX)
      |=> (blk_idx == IDX_W'($past(blk_idx) + 1'b1)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_win && !load_stb && !row_start) |=> $stable(blk_idx));

  p_gate_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_win && !(load_stb && blk_idx == LAST_IDX)) |=> gate_win);

  p_gate_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_win) |-> ($past(load_stb) && $past(blk_idx) == LAST_IDX));

  p_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_win) |-> row_done);

  p_done_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    row_done |-> (!gate_win || $past(row_start)));

  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (row_start && gate_win) |=> (row_abort && gate_win && blk_idx == '0 && !row_done));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_win && !row_start) |=> !gate_win);
endmodule

bind dline_demux_seq dls_checker #(.NUM_BLOCKS(NUM_BLOCKS)) u_dls_checker (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .row_start (row_start),
  .load_stb  (load_stb),
  .blk_en    (blk_en),
  .blk_idx   (blk_idx),
  .gate_win  (gate_win),
  .row_done  (row_done),
  .row_abort (row_abort)
);

// File: tb/dline_demux_seq_bench.sv
module dline_demux_seq_bench;
  localparam int NB = 5;
  localparam int LPB = 256;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        row_start;
  logic        load_stb;
  logic [NB-1:0] blk_en;
  logic [2:0]  blk_idx;
  logic [10:0] col_base;
  logic        gate_win, row_done, row_abort;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic       m_gate, m_done, m_abort;
  int         m_idx;

  always #5 clk = ~clk;

  dline_demux_seq u_dline_demux_seq (
    .clk(clk), .rst_n(rst_n), .row_start(row_start), .load_stb(load_stb),
    .blk_en(blk_en), .blk_idx(blk_idx), .col_base(col_base),
    .gate_win(gate_win), .row_done(row_done), .row_abort(row_abort)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int exp_en(input logic g, input int idx);
    return g ? (1 << idx) : 0;
  endfunction

  task automatic compare_all();
    chk("R3", "blk_en", int'(blk_en), exp_en(m_gate, m_idx));
    chk("R4", "blk_idx", int'(blk_idx), m_idx);
    chk("R5", "col_base", int'(col_base), m_idx * LPB);
    chk("R6", "gate_win", int'(gate_win), int'(m_gate));
    chk("R7", "row_done", int'(row_done), int'(m_done));
    chk("R8", "row_abort", int'(row_abort), int'(m_abort));
  endtask

  task automatic step(input logic rs, input logic ls);
    @(negedge clk);
    row_start = rs;
    load_stb  = ls;
    m_abort = rs && m_gate;
    m_done  = !rs && m_gate && ls && (m_idx == NB - 1);
    if (rs) begin
      m_gate = 1'b1; m_idx = 0;
    end else if (m_gate && ls) begin
      if (m_idx == NB - 1) begin m_gate = 1'b0; m_idx = 0; end
      else m_idx = m_idx + 1;
    end
    @(posedge clk);
    #1;
    compare_all();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; row_start = 1'b0; load_stb = 1'b0;
    m_gate = 1'b0; m_done = 1'b0; m_abort = 1'b0; m_idx = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "gate_win in reset", int'(gate_win), 0);
    chk("R1", "blk_en in reset", int'(blk_en), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "blk_idx after reset", int'(blk_idx), 0);
    chk("R1", "row_done after reset", int'(row_done), 0);
    compare_all();

    // R9: strobe while idle changes nothing
    step(1'b0, 1'b1);
    chk("R9", "gate after idle strobe", int'(gate_win), 0);

    // R2: start a row
    step(1'b1, 1'b0);
    chk("R2", "blk_en after start", int'(blk_en), 1);
    // R4: gaps hold, strobes advance in order
    for (int b = 0; b < NB; b++) begin
      step(1'b0, 1'b0);
      chk("R4", "hold without strobe", int'(blk_idx), b);
      step(1'b0, 1'b1);
    end
    chk("R6", "gate fell after fifth load", int'(gate_win), 0);
    chk("R7", "row_done after fifth load", int'(row_done), 1);
    step(1'b0, 1'b0);
    chk("R7", "row_done one cycle", int'(row_done), 0);

    // R8: abort mid-row
    step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    chk("R8", "abort mid-row", int'(row_abort), 1);
    chk("R8", "restart index", int'(blk_idx), 0);

    // R8: row start collides with fifth strobe
    for (int b = 0; b < NB - 1; b++) step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    chk("R8", "abort wins over fifth load", int'(row_abort), 1);
    chk("R8", "no row_done on collision", int'(row_done), 0);
    chk("R8", "gate still open", int'(gate_win), 1);

    // R2: start in the cycle row_done is high
    for (int b = 0; b < NB; b++) step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    chk("R2", "start after done, no abort", int'(row_abort), 0);
    chk("R2", "start after done gate", int'(gate_win), 1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 24) == 0, ($urandom % 3) != 0);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule